// File: doc/BRIEF.md
# Interrupt Source PQ-State Bank

This block keeps the delivery state of a bank of interrupt sources. Each source owns a two-bit state: P says an event has been forwarded and is waiting for its end-of-interrupt; Q records that another event came in while P was held. A per-source type, fixed by a parameter and kept apart from the runtime state, selects message behaviour (each input pulse is one event) or level behaviour (the input line is the assertion flag, and only P is ever used). When a source fires, the block queues a notification and sends it downstream as a one-cycle pulse carrying the source number.

Software reaches the bank through a small request port. Each source owns two pages: the even page is a trigger page, where a request acts like an input event for a message source, and the odd page is a management page offering end-of-interrupt, read of the state, and write of the state. Every request gets a response one cycle later. A level source that is still held when its end-of-interrupt arrives fires again immediately, so a line that stays asserted is never lost.

Top module: `irq_pq_bank`

## Requirements
- R1: After reset every source holds state 01 (off), no notification is pending, and a source in state 01 never notifies, whatever its input does, until software writes its state.
- R2: A message source treats a cycle with its input at 1 as one event: state 00 moves to 10 and notifies; 10 moves to 11 without notifying; 11 and 01 are left unchanged without notifying.
- R3: A message source ignores a cycle with its input at 0, and a request on its trigger page (address bit 0 equal to 0, source number in the upper address bits) counts as one event exactly like an input pulse; the trigger-page response is 00.
- R4: End-of-interrupt (management page, op 0) on a message source returns the old P in response bit 0 (bit 1 is 0); 11 becomes 10 and notifies again, 10 and 00 become 00 without notifying, 01 stays 01.
- R5: A level source in state 00 with its line high moves to 10 and notifies; holding the line keeps it at 10, since level sources never set Q.
- R6: End-of-interrupt on a level source clears P; if the line is still high it fires again in the same cycle (state 10, new notification), otherwise it rests at 00.
- R7: Op 1 on the management page returns the state as {P,Q} and changes nothing; op 2 returns the old state and loads the write data {P,Q}; every request is answered with a valid response on the following cycle.
- R8: Sources that fire in the same cycle are each notified once, one per cycle, in order of increasing source number; a notification appears on the cycle after the firing event.
- R9: When a management operation and an input event reach the same source in one cycle, the management operation is applied first and the event is then applied to its result.
- R10: Op 3 on the management page and trigger-page requests to a level source have no effect on state and respond 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | NSRC | Per-source input: event pulse (message type) or line level (level type) |
| req_valid | input | 1 | Request strobe |
| req_addr | input | IDW+1 | {source number, page}; page 0 trigger, page 1 management |
| req_op | input | 2 | Management op: 0 end-of-interrupt, 1 read, 2 write, 3 none |
| req_wdata | input | 2 | New {P,Q} for the write op |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_data | output | 2 | Response value |
| notify_valid | output | 1 | Notification pulse |
| notify_idx | output | IDW | Source number of the notification |

## Verification
The two functions that can meet in one cycle are a management operation from software and an input event on the same source. The bench provokes this by driving a management request and the source's input pulse in the same clock cycle, once with end-of-interrupt on a source in state 11 and once with a write of 00. It judges the outcome by the response value, the notification seen on the next cycle, and a follow-up read of the state, which must match the management-then-event order.

// File: rtl/irq_pq_bank.sv
module irq_pq_bank #(
  parameter int NSRC = 8,
  parameter logic [NSRC-1:0] LSI_MASK = 8'hF0,
  localparam int IDW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_in,
  input  logic            req_valid,
  input  logic [IDW:0]    req_addr,
  input  logic [1:0]      req_op,
  input  logic [1:0]      req_wdata,
  output logic            rsp_valid,
  output logic [1:0]      rsp_data,
  output logic            notify_valid,
  output logic [IDW-1:0]  notify_idx
);

  localparam logic [1:0] ST_IDLE = 2'b00;
  localparam logic [1:0] ST_OFF  = 2'b01;
  localparam logic [1:0] ST_SENT = 2'b10;
  localparam logic [1:0] ST_BOTH = 2'b11;

  logic [NSRC-1:0][1:0] pq_q, pq_d;
  logic [NSRC-1:0]      fire, pend_q, grant;
  logic [NSRC-1:0]      hit_trg, hit_mg;
  logic [IDW-1:0]       req_src;
  logic                 page_mg, op_eoi, op_get, op_set;
  logic [1:0]           sel_pq;
  logic                 sel_lsi;

  assign req_src = req_addr[IDW:1];
  assign page_mg = req_addr[0];
  assign op_eoi  = req_op == 2'd0;
  assign op_get  = req_op == 2'd1;
  assign op_set  = req_op == 2'd2;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    localparam bit IS_LSI = LSI_MASK[i];
    logic [1:0] st;
    logic       nt;

    assign hit_trg[i] = req_valid && !page_mg && (req_src == IDW'(i));
    assign hit_mg[i]  = req_valid &&  page_mg && (req_src == IDW'(i));

    always_comb begin
      st = pq_q[i];
      nt = 1'b0;
      if (hit_mg[i] && op_eoi) begin
        if (st != ST_OFF) begin
          if (!IS_LSI && st[0]) begin
            st = ST_SENT;
            nt = 1'b1;
          end else begin
            st = ST_IDLE;
          end
        end
      end else if (hit_mg[i] && op_set) begin
        st = req_wdata;
      end
      if (IS_LSI) begin
        if (st == ST_IDLE && src_in[i]) begin
          st = ST_SENT;
          nt = 1'b1;
        end
      end else if (src_in[i] || hit_trg[i]) begin
        if (st == ST_IDLE) begin
          st = ST_SENT;
          nt = 1'b1;
        end else if (st == ST_SENT) begin
          st = ST_BOTH;
        end
      end
      pq_d[i] = st;
      fire[i] = nt;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) pq_q[i] <= ST_OFF;
      else        pq_q[i] <= pq_d[i];
    end
  end

  always_comb begin
    sel_pq  = 2'b00;
    sel_lsi = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (req_src == IDW'(i)) begin
        sel_pq  = pq_q[i];
        sel_lsi = LSI_MASK[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= 2'b00;
    end else begin
      rsp_valid <= req_valid;
      if (!req_valid || !page_mg) rsp_data <= 2'b00;
      else if (op_eoi)            rsp_data <= {1'b0, sel_pq[1]};
      else if (op_get || op_set)  rsp_data <= sel_pq;
      else                        rsp_data <= 2'b00;
    end
  end

  assign grant = pend_q & (~pend_q + NSRC'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~grant) | fire;
  end

  assign notify_valid = |pend_q;

  always_comb begin
    notify_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend_q[i]) notify_idx = IDW'(i);
    end
  end

  logic unused_sel;
  assign unused_sel = sel_lsi;

endmodule

// File: rtl/irq_pq_bank_chk.sv
module irq_pq_bank_chk #(
  parameter int NSRC = 8,
  parameter logic [NSRC-1:0] LSI_MASK = 8'hF0,
  localparam int IDW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic [1:0]           req_op,
  input logic                 rsp_valid,
  input logic                 notify_valid,
  input logic [IDW-1:0]       notify_idx,
  input logic [NSRC-1:0]      pend_q,
  input logic [NSRC-1:0]      fire,
  input logic [NSRC-1:0]      hit_mg,
  input logic [NSRC-1:0][1:0] pq_q
);

  assert_rsp_next_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_notify_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    notify_valid |-> pend_q[notify_idx]);

  for (genvar i = 0; i < NSRC; i++) begin : g_chk
    assert_off_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (pq_q[i] == 2'b01 && !hit_mg[i]) |-> !fire[i]);

    assert_fire_sets_p_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fire[i] |=> pq_q[i][1]);

    if (LSI_MASK[i]) begin : g_lsi
      assert_level_no_q_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pq_q[i] != 2'b11 && !(hit_mg[i] && req_op == 2'd2)) |=> pq_q[i] != 2'b11);
    end
  end

endmodule

bind irq_pq_bank irq_pq_bank_chk #(.NSRC(NSRC), .LSI_MASK(LSI_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .rsp_valid(rsp_valid), .notify_valid(notify_valid), .notify_idx(notify_idx),
  .pend_q(pend_q), .fire(fire), .hit_mg(hit_mg), .pq_q(pq_q)
);

// File: tb/irq_pq_bank_bench.sv
module irq_pq_bank_bench;
  localparam int NSRC = 8;
  localparam int IDW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSRC-1:0] line_v = '0, pulse_v = '0, src_in;
  logic req_valid = 1'b0;
  logic [IDW:0] req_addr = '0;
  logic [1:0] req_op = '0, req_wdata = '0;
  logic rsp_valid, notify_valid;
  logic [1:0] rsp_data;
  logic [IDW-1:0] notify_idx;
  int checks = 0, failures = 0;

  assign src_in = line_v | pulse_v;
  always #5 clk = ~clk;

  irq_pq_bank #(.NSRC(NSRC), .LSI_MASK(8'hF0)) u_irq_pq_bank (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .req_valid(req_valid),
    .req_addr(req_addr), .req_op(req_op), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .notify_valid(notify_valid), .notify_idx(notify_idx));

  // kinds: 0 idle, 1 pulse, 2 eoi, 3 get, 4 set, 5 trigger page, 6 op 3
  // entry: {kind[2:0], src[2:0], wdata[1:0], exp_rsp[1:0], exp_nv, exp_idx[2:0]}
  localparam int NV = 19;
  localparam logic [13:0] VEC [NV] = '{
    {3'd3, 3'd2, 2'b00, 2'b01, 1'b0, 3'd0},
    {3'd1, 3'd2, 2'b00, 2'b00, 1'b0, 3'd0},
    {3'd4, 3'd2, 2'b00, 2'b01, 1'b0, 3'd0},
    {3'd3, 3'd2, 2'b00, 2'b00, 1'b0, 3'd0},
    {3'd0, 3'd2, 2'b00, 2'b00, 1'b0, 3'd0},
    {3'd1, 3'd2, 2'b00, 2'b00, 1'b1, 3'd2},
    {3'd1, 3'd2, 2'b00, 2'b00, 1'b0, 3'd0},
    {3'd1, 3'd2, 2'b00, 2'b00, 1'b0, 3'd0},
    {3'd3, 3'd2, 2'b00, 2'b11, 1'b0, 3'd0},
    {3'd2, 3'd2, 2'b00, 2'b01, 1'b1, 3'd2},
    {3'd3, 3'd2, 2'b00, 2'b10, 1'b0, 3'd0},
    {3'd2, 3'd2, 2'b00, 2'b01, 1'b0, 3'd0},
    {3'd3, 3'd2, 2'b00, 2'b00, 1'b0, 3'd0},
    {3'd5, 3'd2, 2'b00, 2'b00, 1'b1, 3'd2},
    {3'd2, 3'd2, 2'b00, 2'b01, 1'b0, 3'd0},
    {3'd2, 3'd2, 2'b00, 2'b00, 1'b0, 3'd0},
    {3'd4, 3'd2, 2'b01, 2'b00, 1'b0, 3'd0},
    {3'd2, 3'd2, 2'b00, 2'b00, 1'b0, 3'd0},
    {3'd3, 3'd2, 2'b00, 2'b01, 1'b0, 3'd0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply(input int kind, input int src, input logic [1:0] wd,
                       input logic [NSRC-1:0] pm);
    req_valid = (kind >= 2);
    req_addr  = {IDW'(src), (kind == 2 || kind == 3 || kind == 4 || kind == 6)};
    req_op    = (kind == 2) ? 2'd0 : (kind == 3) ? 2'd1 : (kind == 4) ? 2'd2 : 2'd3;
    req_wdata = wd;
    pulse_v   = pm | ((kind == 1) ? NSRC'(1) << src : '0);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    pulse_v   = '0;
  endtask

  task automatic chk_note(input string tag, input bit nv, input int idx);
    chk(notify_valid == nv, {tag, " notify_valid"}, notify_valid, nv);
    if (nv) chk(notify_idx == IDW'(idx), {tag, " notify_idx"}, notify_idx, idx);
  endtask

  task automatic get_pq(input int src, input logic [1:0] exp, input string tag);
    apply(3, src, 2'b00, '0);
    chk(rsp_valid && rsp_data == exp, tag, rsp_data, exp);
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!notify_valid && !rsp_valid, "R1 outputs quiet in reset", notify_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int s = 0; s < NSRC; s++) get_pq(s, 2'b01, "R1 reset state off");
    apply(1, 0, 2'b00, 8'hFF);
    chk_note("R1 off sources silent", 1'b0, 0);

    // R2 R3 R4 R7 table
    for (int v = 0; v < NV; v++) begin
      logic [13:0] e;
      int k;
      e = VEC[v];
      k = int'(e[13:11]);
      apply(k, int'(e[10:8]), e[7:6], '0);
      if (k >= 2) chk(rsp_valid && rsp_data == e[5:4],
                      $sformatf("R2 R3 R4 R7 table[%0d] rsp", v), rsp_data, e[5:4]);
      chk_note($sformatf("R2 R3 R4 table[%0d]", v), e[3], int'(e[2:0]));
    end

    // R5 / R6 level source 5
    apply(4, 5, 2'b00, '0);
    chk_note("R5 idle low line silent", 1'b0, 0);
    line_v[5] = 1'b1;
    apply(0, 0, 2'b00, '0);
    chk_note("R5 line rise notifies", 1'b1, 5);
    apply(0, 0, 2'b00, '0);
    apply(0, 0, 2'b00, '0);
    chk_note("R5 held line no repeat", 1'b0, 0);
    get_pq(5, 2'b10, "R5 level never sets Q");
    apply(2, 5, 2'b00, '0);
    chk(rsp_data == 2'b01, "R6 eoi returns P", rsp_data, 1);
    chk_note("R6 eoi while held refires", 1'b1, 5);
    get_pq(5, 2'b10, "R6 state after refire");
    line_v[5] = 1'b0;
    apply(2, 5, 2'b00, '0);
    chk_note("R6 eoi after release silent", 1'b0, 0);
    get_pq(5, 2'b00, "R6 rests idle");
    apply(5, 5, 2'b00, '0);
    chk(rsp_data == 2'b00, "R10 trigger page on level rsp", rsp_data, 0);
    chk_note("R10 trigger page on level silent", 1'b0, 0);
    get_pq(5, 2'b00, "R10 trigger page on level no effect");

    // R8 arbitration
    apply(4, 1, 2'b00, '0);
    apply(4, 3, 2'b00, '0);
    apply(4, 6, 2'b00, '0);
    line_v[6] = 1'b1;
    apply(0, 0, 2'b00, 8'b0000_1010);
    chk_note("R8 first lowest", 1'b1, 1);
    @(negedge clk);
    chk_note("R8 second", 1'b1, 3);
    @(negedge clk);
    chk_note("R8 third", 1'b1, 6);
    @(negedge clk);
    chk_note("R8 drained", 1'b0, 0);
    line_v[6] = 1'b0;

    // R9 same-cycle management and event
    apply(4, 2, 2'b11, '0);
    apply(2, 2, 2'b00, 8'b0000_0100);
    chk(rsp_data == 2'b01, "R9 eoi with event rsp", rsp_data, 1);
    chk_note("R9 eoi with event notifies", 1'b1, 2);
    get_pq(2, 2'b11, "R9 eoi then event");
    apply(4, 2, 2'b00, 8'b0000_0100);
    chk_note("R9 set with event notifies", 1'b1, 2);
    get_pq(2, 2'b10, "R9 set then event");

    // R10 reserved op
    apply(6, 2, 2'b00, '0);
    chk(rsp_valid && rsp_data == 2'b00, "R10 op3 rsp", rsp_data, 0);
    get_pq(2, 2'b10, "R10 op3 no effect");

    // R1 reset mid-run, line held
    line_v[5] = 1'b1;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_note("R1 after reset with line high", 1'b0, 0);
    get_pq(5, 2'b01, "R1 reset reloads off");
    get_pq(2, 2'b01, "R1 reset reloads off msg");
    line_v[5] = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule